// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the data-processing stage of a 32-bit integer pipeline. Each accepted operation combines a first register operand with a second operand that the shifter has already prepared. The shifter's carry-out comes in alongside that second operand. A 4-bit opcode selects one of sixteen operations. The block returns the result, a destination write strobe with its register index, and the next N, Z, C and V condition flags.

The carry rule depends on the operation class:
- Additions report the unsigned carry out of the top bit.
- Subtractions report the inverse of the borrow.
- Logical operations pass the shifter carry through unchanged.

The four comparison opcodes only update flags. They never write, and they behave as if the set-flags bit were always set.

Two cases involve the program counter:
- A write to the program counter raises a pipeline refill strobe.
- When flags would be set, the destination is the program counter, and the current mode keeps a saved status word, the flags are left alone. In that case the block instead requests that the saved status word be copied into the current one.

All outputs are registered and appear one clock after the accepted input.

Top module: `dp_alu`

## Requirements
- R1: While and right after synchronous reset, out_valid, wr_en, restore_req, refill, result, wr_idx and flags_out are all zero.
- R2: out_valid equals in_valid of the previous cycle. wr_en, restore_req and refill are zero in any cycle where out_valid is zero.
- R3: Opcode encoding is 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC (a AND NOT b), 15 MVN (NOT b). The logical opcodes produce the corresponding bitwise result; TST behaves like AND and TEQ like EOR.
- R4: Logical opcodes with flags enabled set N from result bit 31, set Z when the result is zero, set C from the shifter carry input, and keep V. The flags vector is {N,Z,C,V} in bits 3..0.
- R5: ADD, ADC and CMN produce the 32-bit sum, with C the unsigned carry out of bit 31 and V the signed overflow.
- R6: SUB and CMP compute rn minus operand, and RSB computes operand minus rn. For all of them C is 1 when no borrow occurs, and V is the signed overflow of the subtraction.
- R7: ADC adds the incoming C flag. SBC and RSC subtract one extra when the incoming C flag is clear.
- R8: TST, TEQ, CMP and CMN never assert wr_en and always update flags, even when set_flags is low.
- R9: When flags are not enabled (set_flags low, non-compare opcode), flags_out equals flags_in.
- R10: When flags are enabled, dest_idx is 15 and has_saved_psr is high, restore_req is asserted and flags_out equals flags_in. Without has_saved_psr the flags are computed normally and no restore is requested.
- R11: refill is asserted exactly when a write occurs with dest_idx equal to 15.
- R12: wr_idx presents the dest_idx of the operation that produced the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted this cycle |
| rn_val | input | 32 | First operand |
| opnd_val | input | 32 | Shifted second operand |
| opnd_carry | input | 1 | Shifter carry-out |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Update flags |
| dest_idx | input | 4 | Destination register index |
| flags_in | input | 4 | Current {N,Z,C,V} |
| has_saved_psr | input | 1 | Current mode keeps a saved status word |
| out_valid | output | 1 | Outputs belong to an operation |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Write destination |
| wr_idx | output | 4 | Destination index |
| flags_out | output | 4 | Next {N,Z,C,V} |
| restore_req | output | 1 | Copy saved status into current status |
| refill | output | 1 | Program counter written, refill pipeline |

## Verification
A flag-setting write to the program counter in a mode with a saved status word raises the refill strobe and the status-restore request in the same cycle, and it must leave the flags untouched while the result is still written. The directed set drives that case with a subtraction. The random set biases the destination toward index 15 and toggles the saved-status input, so that both strobes coincide often. The random set also sends comparisons to index 15, which must request a restore without a refill. Each cycle is judged against a bench model that computes the result, flags and strobes with 64-bit arithmetic.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_LOGIC = 2'd0,
    CLS_ADD   = 2'd1,
    CLS_SUB   = 2'd2
  } alu_cls_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cin_sel_e;

  typedef struct packed {
    alu_cls_e cls;
    logic     swap;
    logic     inv_b;
    cin_sel_e cin_sel;
    logic     cmp_only;
  } alu_dec_t;

  // flag vector bit positions
  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_C = 1;
  localparam int FLG_V = 0;
endpackage

// File: rtl/dp_alu_decode.sv
module dp_alu_decode
  import dp_alu_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output alu_dec_t        dec
);
  always_comb begin
    dec = '{cls: CLS_LOGIC, swap: 1'b0, inv_b: 1'b0, cin_sel: CIN_ZERO, cmp_only: 1'b0};
    unique case (alu_op_e'(opcode))
      OP_ADD, OP_CMN: dec.cls = CLS_ADD;
      OP_ADC: begin
        dec.cls     = CLS_ADD;
        dec.cin_sel = CIN_FLAG;
      end
      OP_SUB, OP_CMP: begin
        dec.cls     = CLS_SUB;
        dec.inv_b   = 1'b1;
        dec.cin_sel = CIN_ONE;
      end
      OP_SBC: begin
        dec.cls     = CLS_SUB;
        dec.inv_b   = 1'b1;
        dec.cin_sel = CIN_FLAG;
      end
      OP_RSB: begin
        dec.cls     = CLS_SUB;
        dec.swap    = 1'b1;
        dec.inv_b   = 1'b1;
        dec.cin_sel = CIN_ONE;
      end
      OP_RSC: begin
        dec.cls     = CLS_SUB;
        dec.swap    = 1'b1;
        dec.inv_b   = 1'b1;
        dec.cin_sel = CIN_FLAG;
      end
      default: dec.cls = CLS_LOGIC;
    endcase
    // opcodes 8..11 are flag-only
    dec.cmp_only = (opcode[OP_W-1:OP_W-2] == 2'b10);
  end
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [OP_W-1:0] opcode,
  output logic [W-1:0]    y
);
  always_comb begin
    unique case (alu_op_e'(opcode))
      OP_AND, OP_TST: y = a & b;
      OP_EOR, OP_TEQ: y = a ^ b;
      OP_ORR:         y = a | b;
      OP_MOV:         y = b;
      OP_BIC:         y = a & ~b;
      OP_MVN:         y = ~b;
      default:        y = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_adder.sv
module dp_alu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int WE = W + 1;
  logic [WE-1:0] wide;

  always_comb begin
    wide = {1'b0, x} + {1'b0, y} + {{(WE-1){1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
    ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
  end
endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_cls_e     cls,
  input  logic         set_eff,
  input  logic         dest_is_pc,
  input  logic         has_saved_psr,
  input  logic [W-1:0] res,
  input  logic         add_cout,
  input  logic         add_ovf,
  input  logic         shift_c,
  input  logic [3:0]   flags_in,
  output logic [3:0]   flags_next,
  output logic         restore
);
  always_comb begin
    restore    = set_eff && dest_is_pc && has_saved_psr;
    flags_next = flags_in;
    if (set_eff && !restore) begin
      flags_next[FLG_N] = res[W-1];
      flags_next[FLG_Z] = (res == '0);
      if (cls == CLS_LOGIC) begin
        flags_next[FLG_C] = shift_c;
      end else begin
        flags_next[FLG_C] = add_cout;
        flags_next[FLG_V] = add_ovf;
      end
    end
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int W      = 32,
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [W-1:0]     rn_val,
  input  logic [W-1:0]     opnd_val,
  input  logic             opnd_carry,
  input  logic [3:0]       opcode,
  input  logic             set_flags,
  input  logic [IDX_W-1:0] dest_idx,
  input  logic [3:0]       flags_in,
  input  logic             has_saved_psr,
  output logic             out_valid,
  output logic [W-1:0]     result,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [3:0]       flags_out,
  output logic             restore_req,
  output logic             refill
);
  localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

  alu_dec_t     dec;
  logic [W-1:0] logic_y;
  logic [W-1:0] add_x, add_y, add_sum;
  logic         add_cin, add_cout, add_ovf;
  logic [W-1:0] res_c;
  logic         set_eff, dest_is_pc, wr_c, refill_c, restore_c;
  logic [3:0]   flags_c;

  dp_alu_decode u_dec (
    .opcode (opcode),
    .dec    (dec)
  );

  dp_alu_logic #(.W(W)) u_logic (
    .a      (rn_val),
    .b      (opnd_val),
    .opcode (opcode),
    .y      (logic_y)
  );

  always_comb begin
    add_x = dec.swap ? opnd_val : rn_val;
    add_y = dec.swap ? rn_val : opnd_val;
    if (dec.inv_b) add_y = ~add_y;
    unique case (dec.cin_sel)
      CIN_ONE:  add_cin = 1'b1;
      CIN_FLAG: add_cin = flags_in[FLG_C];
      default:  add_cin = 1'b0;
    endcase
  end

  dp_alu_adder #(.W(W)) u_add (
    .x    (add_x),
    .y    (add_y),
    .cin  (add_cin),
    .sum  (add_sum),
    .cout (add_cout),
    .ovf  (add_ovf)
  );

  always_comb begin
    res_c      = (dec.cls == CLS_LOGIC) ? logic_y : add_sum;
    set_eff    = set_flags || dec.cmp_only;
    dest_is_pc = (dest_idx == PC_SEL);
    wr_c       = !dec.cmp_only;
    refill_c   = wr_c && dest_is_pc;
  end

  dp_alu_flags #(.W(W)) u_flags (
    .cls           (dec.cls),
    .set_eff       (set_eff),
    .dest_is_pc    (dest_is_pc),
    .has_saved_psr (has_saved_psr),
    .res           (res_c),
    .add_cout      (add_cout),
    .add_ovf       (add_ovf),
    .shift_c       (opnd_carry),
    .flags_in      (flags_in),
    .flags_next    (flags_c),
    .restore       (restore_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      result      <= '0;
      wr_en       <= 1'b0;
      wr_idx      <= '0;
      flags_out   <= '0;
      restore_req <= 1'b0;
      refill      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result      <= res_c;
        wr_en       <= wr_c;
        wr_idx      <= dest_idx;
        flags_out   <= flags_c;
        restore_req <= restore_c;
        refill      <= refill_c;
      end else begin
        wr_en       <= 1'b0;
        restore_req <= 1'b0;
        refill      <= 1'b0;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !(wr_en || restore_req || refill)); // R2
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode[3:2] == 2'b10) |=> !wr_en); // R8
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !set_flags && opcode[3:2] != 2'b10) |=> (flags_out == $past(flags_in))); // R9
  AST_LOGIC_V_KEPT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (opcode[3:2] == 2'b00 || opcode[3:2] == 2'b11) && opcode[3:1] != 3'b001)
      |=> (flags_out[FLG_V] == $past(flags_in[FLG_V]))); // R4
  AST_RESTORE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    restore_req |-> (out_valid && wr_idx == PC_SEL)); // R10
  AST_PC_REFILL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode[3:2] != 2'b10 && dest_idx == PC_SEL) |=> refill); // R11
endmodule

// File: tb/dp_alu_bench.sv
module dp_alu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 20000;
  localparam int N_RAND     = 3000;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] rn_val, opnd_val;
  logic        opnd_carry;
  logic [3:0]  opcode;
  logic        set_flags;
  logic [3:0]  dest_idx;
  logic [3:0]  flags_in;
  logic        has_saved_psr;
  logic        out_valid;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [3:0]  flags_out;
  logic        restore_req;
  logic        refill;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_alu u_dp_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .rn_val(rn_val), .opnd_val(opnd_val),
    .opnd_carry(opnd_carry), .opcode(opcode), .set_flags(set_flags), .dest_idx(dest_idx),
    .flags_in(flags_in), .has_saved_psr(has_saved_psr), .out_valid(out_valid),
    .result(result), .wr_en(wr_en), .wr_idx(wr_idx), .flags_out(flags_out),
    .restore_req(restore_req), .refill(refill)
  );

  // returns {result[31:0], wr, flags[3:0], restore, refill}
  function automatic logic [38:0] model(input logic [31:0] a, input logic [31:0] b,
      input logic sc, input logic [3:0] op, input logic s, input logic [3:0] d,
      input logic [3:0] f, input logic hs);
    logic [31:0] r, x, y;
    logic c, v, se, cmp, rq, wr, bw, ci;
    logic [3:0] nf;
    logic [63:0] usum;
    logic signed [63:0] ssum, sx, sy;
    int kind;
    c = 1'b0; v = 1'b0; kind = 0; r = '0;
    cmp = (op >= 4'd8) && (op <= 4'd11);
    case (op)
      4'd0, 4'd8:  r = a & b;
      4'd1, 4'd9:  r = a ^ b;
      4'd12:       r = a | b;
      4'd13:       r = b;
      4'd14:       r = a & ~b;
      4'd15:       r = ~b;
      4'd4, 4'd5, 4'd11: begin
        kind = 1;
        ci   = (op == 4'd5) ? f[1] : 1'b0;
        usum = {32'd0, a} + {32'd0, b} + {63'd0, ci};
        r    = usum[31:0];
        c    = usum[32];
        sx   = {{32{a[31]}}, a};
        sy   = {{32{b[31]}}, b};
        ssum = sx + sy + {63'd0, ci};
        v    = (ssum > 64'sd2147483647) || (ssum < -64'sd2147483648);
      end
      default: begin
        kind = 2;
        if (op == 4'd3 || op == 4'd7) begin x = b; y = a; end
        else begin x = a; y = b; end
        bw   = (op == 4'd6 || op == 4'd7) ? !f[1] : 1'b0;
        r    = x - y - {31'd0, bw};
        c    = ({32'd0, x} >= ({32'd0, y} + {63'd0, bw}));
        sx   = {{32{x[31]}}, x};
        sy   = {{32{y[31]}}, y};
        ssum = sx - sy - {63'd0, bw};
        v    = (ssum > 64'sd2147483647) || (ssum < -64'sd2147483648);
      end
    endcase
    se = s || cmp;
    rq = se && (d == 4'd15) && hs;
    wr = !cmp;
    nf = f;
    if (se && !rq) begin
      nf[3] = r[31];
      nf[2] = (r == 32'd0);
      nf[1] = (kind == 0) ? sc : c;
      nf[0] = (kind == 0) ? f[0] : v;
    end
    return {r, wr, nf, rq, wr && (d == 4'd15)};
  endfunction

  task automatic check(input string tag, input logic [39:0] got, input logic [39:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (valid,result,wr,flags,restore,refill)", tag, got, exp);
    end
  endtask

  task automatic step(input string tag, input logic [31:0] a, input logic [31:0] b,
      input logic sc, input logic [3:0] op, input logic s, input logic [3:0] d,
      input logic [3:0] f, input logic hs);
    logic [38:0] e;
    in_valid = 1'b1; rn_val = a; opnd_val = b; opnd_carry = sc; opcode = op;
    set_flags = s; dest_idx = d; flags_in = f; has_saved_psr = hs;
    e = model(a, b, sc, op, s, d, f, hs);
    @(negedge clk);
    check(tag, {out_valid, result, wr_en, flags_out, restore_req, refill}, {1'b1, e});
    checks++;
    if (wr_idx !== d) begin
      errors++;
      $display("FAIL R12: wr_idx got %0d expected %0d", wr_idx, d);
    end
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom % 6)
      0: return 32'h0000_0000;
      1: return 32'h7FFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'hFFFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed_void;
    string tag;
    logic [3:0] op, d;
    seed_void = $urandom(32'd20240611);
    rst = 1'b1; in_valid = 1'b0; rn_val = '0; opnd_val = '0; opnd_carry = 1'b0;
    opcode = '0; set_flags = 1'b0; dest_idx = '0; flags_in = '0; has_saved_psr = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {out_valid, result, wr_en, flags_out, restore_req, refill}, 40'd0);
    checks++;
    if (wr_idx !== 4'd0) begin errors++; $display("FAIL R1: wr_idx got %0d expected 0", wr_idx); end
    rst = 1'b0;

    step("R3", 32'hF0F0_F0F0, 32'hFF00_FF00, 1'b0, 4'd0, 1'b0, 4'd1, 4'b0000, 1'b0);
    step("R3", 32'hF0F0_F0F0, 32'hFF00_FF00, 1'b0, 4'd14, 1'b0, 4'd2, 4'b0000, 1'b0);
    step("R4", 32'h1234_5678, 32'h0000_0000, 1'b1, 4'd15, 1'b1, 4'd2, 4'b0001, 1'b0);
    step("R4", 32'hAAAA_5555, 32'hAAAA_5555, 1'b0, 4'd1, 1'b1, 4'd4, 4'b0011, 1'b0);
    step("R5", 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 4'd4, 1'b1, 4'd3, 4'b0000, 1'b0);
    step("R5", 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 4'd4, 1'b1, 4'd3, 4'b0000, 1'b0);
    step("R6", 32'd5, 32'd7, 1'b0, 4'd2, 1'b1, 4'd5, 4'b0000, 1'b0);
    step("R6", 32'd7, 32'd7, 1'b0, 4'd2, 1'b1, 4'd5, 4'b0000, 1'b0);
    step("R6", 32'd3, 32'd10, 1'b0, 4'd3, 1'b1, 4'd5, 4'b0000, 1'b0);
    step("R7", 32'hFFFF_FFFF, 32'd0, 1'b0, 4'd5, 1'b1, 4'd6, 4'b0010, 1'b0);
    step("R7", 32'd10, 32'd3, 1'b0, 4'd6, 1'b1, 4'd6, 4'b0000, 1'b0);
    step("R7", 32'd3, 32'd10, 1'b0, 4'd7, 1'b1, 4'd6, 4'b0000, 1'b0);
    step("R8", 32'd4, 32'd9, 1'b0, 4'd10, 1'b0, 4'd7, 4'b0000, 1'b0);
    step("R8", 32'h8000_0000, 32'h8000_0000, 1'b0, 4'd11, 1'b0, 4'd7, 4'b0000, 1'b0);
    step("R9", 32'hFFFF_FFFF, 32'd1, 1'b0, 4'd4, 1'b0, 4'd8, 4'b1010, 1'b0);
    step("R10", 32'd1, 32'd1, 1'b0, 4'd2, 1'b1, 4'd15, 4'b0101, 1'b1);
    step("R10", 32'd1, 32'd1, 1'b0, 4'd2, 1'b1, 4'd15, 4'b0101, 1'b0);
    step("R11", 32'd8, 32'h100, 1'b0, 4'd13, 1'b0, 4'd15, 4'b0000, 1'b1);
    step("R11", 32'd8, 32'd8, 1'b0, 4'd10, 1'b1, 4'd15, 4'b0000, 1'b1);
    step("R12", 32'd1, 32'd2, 1'b0, 4'd12, 1'b0, 4'd3, 4'b0000, 1'b0);

    // R2 idle cycle
    in_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || wr_en !== 1'b0 || restore_req !== 1'b0 || refill !== 1'b0) begin
      errors++;
      $display("FAIL R2: got valid=%b wr=%b rq=%b rf=%b expected all 0",
               out_valid, wr_en, restore_req, refill);
    end

    for (int i = 0; i < N_RAND; i++) begin
      op = 4'($urandom);
      d  = ($urandom % 4 == 0) ? 4'd15 : 4'($urandom);
      if (op >= 4'd8 && op <= 4'd11) tag = "R8";
      else if (op == 4'd4 || op == 4'd5) tag = "R5";
      else if (op == 4'd2 || op == 4'd3 || op == 4'd6 || op == 4'd7) tag = "R6";
      else tag = "R4";
      step(tag, pick_val(), pick_val(), 1'($urandom), op, 1'($urandom), d,
           4'($urandom), 1'($urandom));
      if ($urandom % 8 == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || wr_en !== 1'b0 || refill !== 1'b0 || restore_req !== 1'b0) begin
          errors++;
          $display("FAIL R2: idle cycle got valid=%b wr=%b expected 0 0", out_valid, wr_en);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule